// File: doc/BRIEF.md
# Selectable Asynchronous Timer Prescaler

This block produces the count enable for one timer channel. Its ten-bit divider runs from one of two clocks: the main system clock, or a slow oscillator input meant for a 32.768 kHz watch crystal. A three-bit select input picks which divider tap drives the enable. The choices are the undivided source, the source divided by 8, 32, 64, 128, 256 or 1024, and stop. The enable is a single-cycle pulse in the source-clock domain. It is not a derived clock.

A small control register in the system domain holds three bits. The prescaler-reset bit clears the divider, so software can start from a known phase. The bit clears itself, but when the divider runs from the oscillator the bit stays set until the clear has taken effect in that slow domain. The request crosses into the oscillator domain and the acknowledge comes back, each through a two-flop synchronizer. A synchronization-mode bit stops the hardware from clearing the reset bits, which holds the prescaler in reset until software drops the mode bit. A third bit serves the neighbouring synchronous prescaler. Its position is fixed so that the neighbour can decode it.

The block moves no data stream, so it has no valid/ready handshake. All pins are plain control and status.

Top module: `async_timer_prescaler`

## Requirements
- R1: After reset the control register reads 0x00 and the enable is low. The register layout is: bit 7 is the synchronization-mode bit, bit 1 is the async prescaler-reset bit, bit 0 is the neighbour's reset bit, and bits 6 to 2 always read zero.
- R2: Select code 000 stops the prescaler, and the enable is never asserted.
- R3: Select code 001 asserts the enable on every source-clock cycle while the divider is not held in reset.
- R4: Select codes 010, 011, 100, 101, 110 and 111 divide by 8, 32, 64, 128, 256 and 1024. After a divider clear, the first enable comes N-1 cycles after the cycle in which the count is zero, and later enables come every N cycles.
- R5: With the system clock as source, writing one to bit 1 clears the divider at the next edge. Bit 1 reads back as zero one cycle after the write. No enable is given while the clear is pending.
- R6: With the oscillator as source, bit 1 reads one until the divider has been cleared in the oscillator domain and that acknowledge has returned through two system-clock flops. Only then does bit 1 clear.
- R7: While bit 7 is set, hardware leaves bits 1 and 0 at one, the divider stays cleared and no enable is given. Clearing bit 7 lets bits 1 and 0 clear and counting resume.
- R8: A change of the select input takes effect at the next source-clock edge and does not clear the divider.
- R9: When `async_sel` is high, the divider counts edges of `clk_osc` rather than `clk_sys`.
- R10: Writing zero to bit 1 or bit 0 has no effect. Only hardware clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Main system clock; the register domain |
| clk_osc | input | 1 | Slow oscillator clock input |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| async_sel | input | 1 | 1 = divider runs from clk_osc; 0 = from clk_sys |
| clk_sel | input | 3 | Tap select: 000 stop, 001 /1, 010 /8, 011 /32, 100 /64, 101 /128, 110 /256, 111 /1024 |
| ctl_wr | input | 1 | Control register write strobe (clk_sys) |
| ctl_wdata | input | 8 | Control register write data |
| ctl_rdata | output | 8 | Control register read value |
| tick | output | 1 | Count-enable pulse in the selected source domain |

## Verification
In the system-clock source mode, a register write at edge E sets bit 1 at once. At edge E+1 the divider is cleared and bit 1 falls. The tap with divide ratio N then gives its first enable N-1 edges later and its next one N edges after that. The bench samples at falling edges and counts edges from the clear, so every expected value is an exact cycle count. In the oscillator source mode, bit 1 clears at a time that depends on two unrelated clocks. The bench therefore checks that bit 1 is still set a few system cycles after the write and cleared within a bounded window. It then measures the enable period in oscillator edges.

// File: rtl/atp_pkg.sv
package atp_pkg;
  typedef enum logic [2:0] {
    SEL_STOP    = 3'd0,
    SEL_DIV1    = 3'd1,
    SEL_DIV8    = 3'd2,
    SEL_DIV32   = 3'd3,
    SEL_DIV64   = 3'd4,
    SEL_DIV128  = 3'd5,
    SEL_DIV256  = 3'd6,
    SEL_DIV1024 = 3'd7
  } tap_sel_e;

  localparam int CTL_W        = 8;
  localparam int CTL_HOLD_BIT = 7;
  localparam int CTL_ARST_BIT = 1;
  localparam int CTL_SRST_BIT = 0;

  // log2 of the divide ratio for each divided tap code
  function automatic int tap_shift(input int code);
    case (code)
      2:       return 3;
      3:       return 5;
      4:       return 6;
      5:       return 7;
      6:       return 8;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/atp_ctrl_reg.sv
module atp_ctrl_reg
  import atp_pkg::*;
#(
  parameter int ACK_STAGES = 2
) (
  input  logic             clk_sys,
  input  logic             rst_n,
  input  logic             async_sel,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  input  logic             ack_src,
  output logic [CTL_W-1:0] rdata,
  output logic             arst_req
);
  logic hold_q, arst_q, srst_q;
  logic [ACK_STAGES-1:0] ack_sync;
  logic ack_seen, arst_done, set_a, set_s;
  logic unused_wbits;

  assign unused_wbits = ^wdata[CTL_HOLD_BIT-1:CTL_ARST_BIT+1];
  assign set_a = wr_en && wdata[CTL_ARST_BIT];
  assign set_s = wr_en && wdata[CTL_SRST_BIT];

  // acknowledge from the source domain, two flops deep
  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) ack_sync <= '0;
    else        ack_sync <= {ack_sync[ACK_STAGES-2:0], ack_src};
  end
  assign ack_seen  = ack_sync[ACK_STAGES-1];
  assign arst_done = async_sel ? ack_seen : 1'b1;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      arst_q <= 1'b0;
      srst_q <= 1'b0;
    end else begin
      if (wr_en) hold_q <= wdata[CTL_HOLD_BIT];
      if (set_a)                                 arst_q <= 1'b1;
      else if (arst_q && !hold_q && arst_done)   arst_q <= 1'b0;
      if (set_s)                    srst_q <= 1'b1;
      else if (srst_q && !hold_q)   srst_q <= 1'b0;
    end
  end

  always_comb begin
    rdata               = '0;
    rdata[CTL_HOLD_BIT] = hold_q;
    rdata[CTL_ARST_BIT] = arst_q;
    rdata[CTL_SRST_BIT] = srst_q;
  end
  assign arst_req = arst_q;

  assert_sync_selfclear_R5: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!async_sel && arst_q && !hold_q && !set_a) |=> !arst_q);
  assert_async_pending_R6: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (async_sel && arst_q && !ack_seen) |=> arst_q);
  assert_hold_keeps_R7: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (hold_q && arst_q) |=> arst_q);
endmodule

// File: rtl/atp_divider.sv
module atp_divider #(
  parameter int DIV_W = 10
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic             async_sel,
  input  logic             arst_req,
  output logic [DIV_W-1:0] cnt,
  output logic             clr,
  output logic             ack
);
  logic req_s1, req_s2;

  // request into the source domain, two flops deep
  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
    end else begin
      req_s1 <= arst_req;
      req_s2 <= req_s1;
    end
  end

  assign clr = async_sel ? req_s2 : arst_req;

  always_ff @(posedge clk_src or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ack <= 1'b0;
    end else begin
      cnt <= clr ? '0 : cnt + 1'b1;
      ack <= req_s2;   // rises on the same edge that zeroes the divider
    end
  end

  assert_clear_zeroes_R5: assert property (@(posedge clk_src) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/atp_tap_sel.sv
module atp_tap_sel
  import atp_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_src,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] cnt,
  input  logic             clr,
  input  tap_sel_e         sel,
  output logic             tick
);
  localparam int NTAPS = 8;
  logic [NTAPS-1:0] hit;

  assign hit[SEL_STOP] = 1'b0;
  assign hit[SEL_DIV1] = 1'b1;
  for (genvar g = 2; g < NTAPS; g++) begin : g_tap
    localparam int SH = tap_shift(g);
    assign hit[g] = &cnt[SH-1:0];
  end

  assign tick = !clr && hit[sel];

  assert_div_single_R4: assert property (@(posedge clk_src) disable iff (!rst_n)
    (tick && sel >= SEL_DIV8 && $stable(sel)) |=> !tick);
endmodule

// File: rtl/async_timer_prescaler.sv
module async_timer_prescaler
  import atp_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_sys,
  input  logic             clk_osc,
  input  logic             rst_n,
  input  logic             async_sel,
  input  logic [2:0]       clk_sel,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             tick
);
  logic             clk_src;
  logic             arst_req, clr, ack;
  logic [DIV_W-1:0] cnt;

  // source clock choice (R9)
  assign clk_src = async_sel ? clk_osc : clk_sys;

  atp_ctrl_reg #(.ACK_STAGES(2)) u_ctrl (
    .clk_sys  (clk_sys),
    .rst_n    (rst_n),
    .async_sel(async_sel),
    .wr_en    (ctl_wr),
    .wdata    (ctl_wdata),
    .ack_src  (ack),
    .rdata    (ctl_rdata),
    .arst_req (arst_req)
  );

  atp_divider #(.DIV_W(DIV_W)) u_div (
    .clk_src  (clk_src),
    .rst_n    (rst_n),
    .async_sel(async_sel),
    .arst_req (arst_req),
    .cnt      (cnt),
    .clr      (clr),
    .ack      (ack)
  );

  atp_tap_sel #(.DIV_W(DIV_W)) u_tap (
    .clk_src(clk_src),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .clr    (clr),
    .sel    (tap_sel_e'(clk_sel)),
    .tick   (tick)
  );

  assert_stop_silent_R2: assert property (@(posedge clk_src) disable iff (!rst_n)
    (clk_sel == 3'd0) |-> !tick);
endmodule

// File: tb/async_timer_prescaler_test.sv
module async_timer_prescaler_test;
  logic       clk_sys = 1'b0;
  logic       clk_osc = 1'b0;
  logic       rst_n = 1'b0;
  logic       async_sel = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2  clk_sys = ~clk_sys;   // 250 MHz
  always #22 clk_osc = ~clk_osc;

  async_timer_prescaler uut (
    .clk_sys(clk_sys), .clk_osc(clk_osc), .rst_n(rst_n), .async_sel(async_sel),
    .clk_sel(clk_sel), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .tick(tick)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_sys); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk_sys); ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic gap_to_tick(output int c);
    c = 0;
    do begin @(negedge clk_sys); c++; end while (!tick && c < 3000);
  endtask

  task automatic t_reset();
    chk(ctl_rdata == 8'h00, "R1", "reset rdata", ctl_rdata, 0);
    chk(tick == 1'b0, "R1", "reset tick", tick, 0);
  endtask

  task automatic t_layout();
    wr(8'h83);
    chk(ctl_rdata == 8'h83, "R1", "rdata after 0x83", ctl_rdata, 8'h83);
    wr(8'h80);
    chk(ctl_rdata == 8'h83, "R10", "zero write ignored", ctl_rdata, 8'h83);
    wr(8'h00);
    chk(ctl_rdata == 8'h03, "R7", "reset bits one cycle after release", ctl_rdata, 8'h03);
    @(negedge clk_sys);
    chk(ctl_rdata == 8'h00, "R7", "reset bits cleared", ctl_rdata, 0);
    wr(8'h7C);
    chk(ctl_rdata == 8'h00, "R1", "bits 6:2 read zero", ctl_rdata, 0);
  endtask

  task automatic t_stop();
    int n = 0;
    clk_sel = 3'd0;
    wr(8'h02);
    repeat (100) begin @(negedge clk_sys); if (tick) n++; end
    chk(n == 0, "R2", "ticks in stop", n, 0);
  endtask

  task automatic t_undiv();
    int n = 0;
    clk_sel = 3'd1;
    wr(8'h02);
    chk(tick == 1'b0, "R5", "no tick while clear pending", tick, 0);
    repeat (10) begin @(negedge clk_sys); if (tick) n++; end
    chk(n == 10, "R3", "undivided ticks in 10 cycles", n, 10);
  endtask

  task automatic t_tap(input logic [2:0] code, input int ratio);
    int c;
    clk_sel = code;
    wr(8'h02);
    chk(ctl_rdata[1] == 1'b1, "R5", "reset bit set after write", ctl_rdata[1], 1);
    @(negedge clk_sys);
    chk(ctl_rdata[1] == 1'b0, "R5", "reset bit self-cleared", ctl_rdata[1], 0);
    gap_to_tick(c);
    chk(c == ratio - 1, "R4", $sformatf("first tick code %0d", code), c, ratio - 1);
    gap_to_tick(c);
    chk(c == ratio, "R4", $sformatf("period code %0d", code), c, ratio);
  endtask

  task automatic t_hold();
    int n = 0;
    int c;
    clk_sel = 3'd2;
    wr(8'h82);
    repeat (40) begin @(negedge clk_sys); if (tick) n++; end
    chk(n == 0, "R7", "ticks while held", n, 0);
    chk(ctl_rdata == 8'h82, "R7", "rdata while held", ctl_rdata, 8'h82);
    wr(8'h00);
    @(negedge clk_sys);
    chk(ctl_rdata == 8'h00, "R7", "released rdata", ctl_rdata, 0);
    gap_to_tick(c);
    chk(c == 7, "R7", "first tick after release", c, 7);
  endtask

  task automatic t_selchange();
    int c;
    clk_sel = 3'd2;
    wr(8'h02);
    @(negedge clk_sys);
    repeat (10) @(negedge clk_sys);   // count now 10
    clk_sel = 3'd3;
    gap_to_tick(c);
    chk(c == 21, "R8", "divider kept across select change", c, 21);
  endtask

  task automatic t_async();
    int c = 0;
    int p = 0;
    async_sel = 1'b1;
    clk_sel = 3'd2;
    repeat (5) @(negedge clk_osc);
    @(negedge clk_sys);
    wr(8'h02);
    chk(ctl_rdata[1] == 1'b1, "R6", "pending right after write", ctl_rdata[1], 1);
    repeat (3) @(negedge clk_sys);
    chk(ctl_rdata[1] == 1'b1, "R6", "still pending 3 cycles later", ctl_rdata[1], 1);
    while (ctl_rdata[1] && c < 300) begin @(negedge clk_sys); c++; end
    chk(ctl_rdata[1] == 1'b0, "R6", "reset bit cleared by ack", ctl_rdata[1], 0);
    chk(c >= 10, "R6", "clear waited for slow domain", c, 10);
    c = 0;
    while (!tick && c < 50) begin @(negedge clk_osc); c++; end
    do begin @(negedge clk_osc); p++; end while (!tick && p < 50);
    chk(p == 8, "R9", "period in oscillator edges", p, 8);
    async_sel = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk_sys);
    rst_n = 1'b1;
    @(negedge clk_sys);
    t_reset();
    t_layout();
    t_stop();
    t_undiv();
    t_tap(3'd2, 8);
    t_tap(3'd3, 32);
    t_tap(3'd4, 64);
    t_tap(3'd5, 128);
    t_tap(3'd6, 256);
    t_tap(3'd7, 1024);
    t_hold();
    t_selchange();
    t_async();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_sys);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule